// File: doc/BRIEF.md
# Write-Once System Options Controller

This block holds an 8-bit system options register that software may program exactly once after each reset. The register sets up a computer-operating-properly (COP) watchdog, decides whether stop requests are legal, and selects whether a shared pin carries the debug function or acts as a plain output. After the first write lands, the contents are frozen until the next reset, so a runaway program cannot switch the watchdog off or enable stop mode by accident.

The watchdog counts bus clock cycles and has two timeout lengths, 2^SHORT_LOG2 or 2^LONG_LOG2 cycles. A service pulse restarts the count. The block raises a one-cycle reset request with a cause code in two cases: when the watchdog runs out, or when a stop request arrives while stop mode is not allowed. The reset generator that consumes this request lies outside the block.

Top module: `sysopt_ctrl`

## Requirements
- R1: Only the first write after reset that is not discarded updates the register, and it locks it. Every later write has no effect until `rst`. A write that carries the reset default values still locks the register.
- R2: `rd_data` can be read at any time. Bit 7 is the watchdog enable, bit 6 the long-timeout select, bit 5 the stop enable, and bit 1 the debug-pin select. Bits 3 and 2 always read 0. Bits 4 and 0 always read 1. Writes never change bits 4, 3, 2 and 0, so the value read after reset is 0xD3.
- R3: After reset, `cop_en`=1, `cop_long`=1, `stop_en`=0 and `dbg_pin_en`=1.
- R4: While the watchdog is enabled and not serviced, `rst_req` is high with `rst_cause`=01 right after the N-th rising edge that follows reset release or the last restart. N is 2^SHORT_LOG2 when bit 6 is 0 and 2^LONG_LOG2 when bit 6 is 1. `rst_req` is low before that edge.
- R5: A one-cycle `svc` pulse clears the watchdog count, so the next timeout comes N edges after the servicing edge.
- R6: While the watchdog is disabled, its count is held at zero and no timeout request is raised.
- R7: When `stop_req` is high on an edge while stop is not enabled, `rst_req` is high with `rst_cause`=10 after that edge. When stop is enabled, a stop request raises no reset request.
- R8: A write that arrives on the same edge as a watchdog expiry is discarded and does not lock the register.
- R9: `rst_req` lasts one cycle for each event. `rst_cause` is 00 while `rst_req` is low. If an expiry and an illegal stop fall on the same edge, the cause is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| svc | input | 1 | Watchdog service pulse |
| stop_req | input | 1 | Request to enter stop mode |
| cop_en | output | 1 | Watchdog enabled |
| cop_long | output | 1 | Long timeout selected |
| stop_en | output | 1 | Stop mode allowed |
| dbg_pin_en | output | 1 | Shared pin in debug function |
| rst_req | output | 1 | Reset request pulse |
| rst_cause | output | 2 | Reset cause: 01 watchdog, 10 illegal stop |

## Verification
A watchdog expiry can fall on the same edge as either a register write or an illegal stop request. The bench counts edges from reset release and drives the write, or the stop request, so that it is present exactly on the expiry edge. For the write, it checks that the request fires, that the read-back still shows 0xD3, and that a later write is still accepted. For the stop request, it checks that the cause is reported as 01.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

    // Register bit positions (read-back layout)
    localparam int BIT_COP_EN   = 7;
    localparam int BIT_COP_LONG = 6;
    localparam int BIT_STOP_EN  = 5;
    localparam int BIT_FIX_HI   = 4;
    localparam int BIT_DBG      = 1;
    localparam int BIT_FIX_LO   = 0;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_COP  = 2'b01,
        CAUSE_STOP = 2'b10
    } cause_t;

    typedef struct packed {
        logic cop_en;
        logic cop_long;
        logic stop_en;
        logic dbg_en;
    } opt_t;

    localparam opt_t OPT_RESET = '{cop_en: 1'b1, cop_long: 1'b1, stop_en: 1'b0, dbg_en: 1'b1};

endpackage

// File: rtl/sysopt_reg.sv
module sysopt_reg
    import sysopt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       block_wr,
    input  opt_t       wr_opt,
    output opt_t       opt,
    output logic [7:0] rd_data
);

    typedef struct packed {
        opt_t opt;
        logic locked;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !block_wr && !st_q.locked) begin
            st_d.opt    = wr_opt;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.opt    <= OPT_RESET;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opt = st_q.opt;

    always_comb begin
        rd_data               = 8'h00;
        rd_data[BIT_COP_EN]   = st_q.opt.cop_en;
        rd_data[BIT_COP_LONG] = st_q.opt.cop_long;
        rd_data[BIT_STOP_EN]  = st_q.opt.stop_en;
        rd_data[BIT_FIX_HI]   = 1'b1;
        rd_data[BIT_DBG]      = st_q.opt.dbg_en;
        rd_data[BIT_FIX_LO]   = 1'b1;
    end

    // R1: once locked, settings never move until reset
    a_r1_locked_stable: assert property (@(posedge clk) disable iff (rst)
        st_q.locked |=> $stable(st_q.opt));

    // R8: a write blocked by an expiry leaves all state untouched
    a_r8_blocked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && block_wr) |=> $stable(st_q));

endmodule

// File: rtl/sysopt_cop.sv
module sysopt_cop #(
    parameter int SHORT_LOG2 = 13,
    parameter int LONG_LOG2  = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic long_sel,
    input  logic svc,
    output logic expire
);

    localparam int CW = LONG_LOG2;
    localparam logic [CW-1:0] LIM_LONG  = {CW{1'b1}};
    localparam logic [CW-1:0] LIM_SHORT = CW'((64'd1 << SHORT_LOG2) - 64'd1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cop_state_t;

    cop_state_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim    = long_sel ? LIM_LONG : LIM_SHORT;
        st_d   = st_q;
        expire = 1'b0;
        if (!en || svc) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a service pulse restarts the count
    a_r5_svc_clears: assert property (@(posedge clk) disable iff (rst)
        svc |=> (st_q.cnt == '0));

    // R6: a disabled watchdog holds its count at zero
    a_r6_off_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0));

endmodule

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
    import sysopt_pkg::*;
#(
    parameter int SHORT_LOG2 = 13,
    parameter int LONG_LOG2  = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       svc,
    input  logic       stop_req,
    output logic       cop_en,
    output logic       cop_long,
    output logic       stop_en,
    output logic       dbg_pin_en,
    output logic       rst_req,
    output logic [1:0] rst_cause
);

    typedef struct packed {
        logic   req;
        cause_t cause;
    } req_state_t;

    opt_t       opt, wr_opt;
    logic       expire;
    logic       illegal_stop;
    logic       unused_wr_bits;
    req_state_t st_d, st_q;

    always_comb begin
        wr_opt.cop_en   = wr_data[BIT_COP_EN];
        wr_opt.cop_long = wr_data[BIT_COP_LONG];
        wr_opt.stop_en  = wr_data[BIT_STOP_EN];
        wr_opt.dbg_en   = wr_data[BIT_DBG];
    end

    assign unused_wr_bits = ^{wr_data[4], wr_data[3], wr_data[2], wr_data[0]};

    sysopt_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .block_wr (expire),
        .wr_opt   (wr_opt),
        .opt      (opt),
        .rd_data  (rd_data)
    );

    sysopt_cop #(
        .SHORT_LOG2 (SHORT_LOG2),
        .LONG_LOG2  (LONG_LOG2)
    ) u_cop (
        .clk      (clk),
        .rst      (rst),
        .en       (opt.cop_en),
        .long_sel (opt.cop_long),
        .svc      (svc),
        .expire   (expire)
    );

    assign illegal_stop = stop_req && !opt.stop_en;

    always_comb begin
        st_d.req   = 1'b0;
        st_d.cause = CAUSE_NONE;
        if (expire) begin
            st_d.req   = 1'b1;
            st_d.cause = CAUSE_COP;
        end else if (illegal_stop) begin
            st_d.req   = 1'b1;
            st_d.cause = CAUSE_STOP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.req   <= 1'b0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cop_en     = opt.cop_en;
    assign cop_long   = opt.cop_long;
    assign stop_en    = opt.stop_en;
    assign dbg_pin_en = opt.dbg_en;
    assign rst_req    = st_q.req;
    assign rst_cause  = st_q.cause;

    // R7: an illegal stop produces a stop-cause request on the next cycle
    a_r7_illegal_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !stop_en && !expire) |=> (rst_req && rst_cause == 2'b10));

    // R9: cause is one-hot while requesting and zero otherwise
    a_r9_cause_coding: assert property (@(posedge clk) disable iff (rst)
        rst_req ? $onehot(rst_cause) : (rst_cause == 2'b00));

    // R4: an expiry always surfaces as a watchdog-cause request
    a_r4_expire_req: assert property (@(posedge clk) disable iff (rst)
        expire |=> (rst_req && rst_cause == 2'b01));

endmodule

// File: tb/sysopt_ctrl_bench.sv
module sysopt_ctrl_bench;

    localparam int SH = 4;
    localparam int LG = 6;
    localparam int NS = 1 << SH;
    localparam int NL = 1 << LG;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       svc;
    logic       stop_req;
    logic       cop_en, cop_long, stop_en, dbg_pin_en;
    logic       rst_req;
    logic [1:0] rst_cause;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sysopt_ctrl #(.SHORT_LOG2(SH), .LONG_LOG2(LG)) u_sysopt_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .svc(svc), .stop_req(stop_req), .cop_en(cop_en), .cop_long(cop_long),
        .stop_en(stop_en), .dbg_pin_en(dbg_pin_en), .rst_req(rst_req), .rst_cause(rst_cause)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; svc = 1'b0; stop_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(rd_data == 8'hD3, "R2 reset read", rd_data, 8'hD3);
        chk({cop_en, cop_long, stop_en, dbg_pin_en} == 4'b1101, "R3 reset fields",
            {cop_en, cop_long, stop_en, dbg_pin_en}, 4'b1101);
        chk(rst_req == 1'b0 && rst_cause == 2'b00, "R9 idle", {rst_req, rst_cause}, 0);
    endtask

    task automatic t_long_timeout();
        int miss = 0;
        do_reset();
        for (int k = 1; k <= NL; k++) begin
            @(negedge clk);
            if (k < NL && rst_req) miss++;
        end
        chk(miss == 0, "R4 early long request", miss, 0);
        chk(rst_req && rst_cause == 2'b01, "R4 long expiry", {rst_req, rst_cause}, 3'b101);
        @(negedge clk);
        chk(!rst_req && rst_cause == 2'b00, "R9 single pulse", {rst_req, rst_cause}, 0);
    endtask

    task automatic t_write_lock();
        do_reset();
        do_write(8'h2C);
        chk(rd_data == 8'h31, "R2 write read", rd_data, 8'h31);
        chk({cop_en, cop_long, stop_en, dbg_pin_en} == 4'b0010, "R1 first write",
            {cop_en, cop_long, stop_en, dbg_pin_en}, 4'b0010);
        do_write(8'hFF);
        chk(rd_data == 8'h31, "R1 second write ignored", rd_data, 8'h31);
        do_reset();
        do_write(8'h00);
        chk(rd_data == 8'h11, "R1 unlocked after reset", rd_data, 8'h11);
    endtask

    task automatic t_same_default();
        do_reset();
        do_write(8'hC2);
        do_write(8'h00);
        chk(rd_data == 8'hD3, "R1 default write locks", rd_data, 8'hD3);
        chk(cop_en == 1'b1, "R1 default write keeps cop", cop_en, 1);
    endtask

    task automatic t_short_timeout();
        int miss = 0;
        do_reset();
        wr_en = 1'b1; wr_data = 8'h80;
        for (int k = 1; k <= NS; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (k < NS && rst_req) miss++;
        end
        chk(cop_long == 1'b0, "R4 short selected", cop_long, 0);
        chk(miss == 0, "R4 early short request", miss, 0);
        chk(rst_req && rst_cause == 2'b01, "R4 short expiry", {rst_req, rst_cause}, 3'b101);
    endtask

    task automatic t_service();
        int miss = 0;
        do_reset();
        repeat (40) @(negedge clk);
        svc = 1'b1;
        @(negedge clk);
        svc = 1'b0;
        for (int k = 1; k <= NL; k++) begin
            @(negedge clk);
            if (k < NL && rst_req) miss++;
        end
        chk(miss == 0, "R5 no request after service", miss, 0);
        chk(rst_req && rst_cause == 2'b01, "R5 expiry after service", {rst_req, rst_cause}, 3'b101);
    endtask

    task automatic t_disabled();
        int hits = 0;
        do_reset();
        do_write(8'h00);
        for (int k = 0; k < 3 * NL; k++) begin
            @(negedge clk);
            if (rst_req) hits++;
        end
        chk(hits == 0, "R6 disabled no timeout", hits, 0);
    endtask

    task automatic t_illegal_stop();
        int hits = 0;
        do_reset();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(rst_req && rst_cause == 2'b10, "R7 illegal stop", {rst_req, rst_cause}, 3'b110);
        @(negedge clk);
        chk(!rst_req, "R9 stop pulse ends", rst_req, 0);
        do_reset();
        do_write(8'h20);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        if (rst_req) hits++;
        @(negedge clk);
        if (rst_req) hits++;
        chk(hits == 0, "R7 legal stop no request", hits, 0);
    endtask

    task automatic t_write_on_expiry();
        do_reset();
        for (int k = 1; k <= NL; k++) begin
            if (k == NL) begin wr_en = 1'b1; wr_data = 8'h00; end
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(rst_req && rst_cause == 2'b01, "R8 expiry fires", {rst_req, rst_cause}, 3'b101);
        chk(rd_data == 8'hD3, "R8 write discarded", rd_data, 8'hD3);
        do_write(8'h00);
        chk(rd_data == 8'h11, "R8 not locked by discard", rd_data, 8'h11);
    endtask

    task automatic t_priority();
        do_reset();
        for (int k = 1; k <= NL; k++) begin
            if (k == NL) stop_req = 1'b1;
            @(negedge clk);
        end
        stop_req = 1'b0;
        chk(rst_req && rst_cause == 2'b01, "R9 watchdog wins", {rst_req, rst_cause}, 3'b101);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_long_timeout();
        t_write_lock();
        t_same_default();
        t_short_timeout();
        t_service();
        t_disabled();
        t_illegal_stop();
        t_write_on_expiry();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule